// File: doc/BRIEF.md
# Bus Slot Isolation Controller

This block sits beside a shared parallel backplane bus and owns the switch enables that join each plug-in slot to it. Every slot has one enable for its supply rail and one for each of several signal-line groups (arbitration, interrupt, serial sideband). A slot that a detector reports as faulty is cut off completely: power and every group. The switches are static. They move only when a slot is removed for a fault, when it is put back by an explicit rejoin command, or during a search.

When the bus has failed and no detector can name the guilty slot, software starts a search. The controller disconnects one candidate slot at a time. It waits a programmable settle time and then samples a bus-healthy input. The first slot whose removal makes the bus healthy is declared faulty and stays cut off. Every other slot is reconnected, and the result is reported as a sticky found flag with the slot index, or as a miss flag.

A daisy-chain line runs through all slots. An isolated slot is bridged so that the chain still reaches the slots downstream of it. While a slot is isolated, a sideband line on the module side can be sampled and driven by the controller.

Top module: `slot_guard_ctrl`

## Requirements
- R1: After reset every slot is connected (status code 0), all power and group enables are high when no group cut is requested, the search is idle, and the found and miss flags are low.
- R2: A pulse on `fault_req_i[i]` makes slot i faulty (status code 1) from the next cycle on. Its power enable and all of its group enables are then low.
- R3: While slot i is connected, `grp_cut_i[i*G+g]` lowers only group enable `grp_en_o[i*G+g]`. Power and the other groups stay on.
- R4: The chain input of slot 0 is `chain_in_i`. The chain input of slot i+1 is the chain input of slot i when slot i is isolated, and `mod_chain_out_i[i]` when slot i is connected. `chain_tail_o` is the value leaving the last slot.
- R5: `side_sample_o[i]` shows `mod_side_in_i[i]` and `side_drv_en_o[i]`/`side_drv_o[i]` follow `side_drv_req_i[i]`/`side_drv_val_i[i]` only while slot i is isolated. When the slot is connected all three are 0.
- R6: A search started by `search_go_i` trials non-faulty slots one at a time in ascending index order. Faulty slots are skipped. A trialled slot shows status code 2 with its enables low, and each trial lasts `settle_cycles_i`+1 cycles. The bus-healthy input is sampled in the last cycle of each trial.
- R7: If `bus_ok_i` is high at the end of a trial, the search ends and that slot becomes faulty. All other trialled slots are connected again, `found_o` goes high and `found_idx_o` gives the slot.
- R8: If no trial restores the bus, the search ends with every trialled slot connected, `miss_o` high and `found_o` low.
- R9: A pulse on `rejoin_req_i[i]` returns a faulty slot i to connected and clears `found_o` when `found_idx_o` equals i. On a connected slot it has no effect.
- R10: A power enable rises only in the cycle after a rejoin of that slot or after a cycle in which a search was running.
- R11: `search_go_i` is ignored while a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req_i | input | N | Per-slot fault report from detectors |
| rejoin_req_i | input | N | Per-slot reintegration command |
| grp_cut_i | input | N*G | Per-slot, per-group disconnect request |
| search_go_i | input | 1 | Start a culprit search |
| settle_cycles_i | input | SW | Extra hold cycles per trial |
| bus_ok_i | input | 1 | Bus-healthy verdict from bus monitor |
| chain_in_i | input | 1 | Daisy chain into slot 0 |
| mod_chain_out_i | input | N | Daisy chain value leaving each module |
| mod_side_in_i | input | N | Module-side sideband line value |
| side_drv_req_i | input | N | Request to drive the module-side sideband |
| side_drv_val_i | input | N | Value to drive on the sideband |
| pwr_en_o | output | N | Power switch enable per slot |
| grp_en_o | output | N*G | Signal-group switch enables, slot-major |
| slot_status_o | output | 2*N | Per-slot code: 0 connected, 1 faulty, 2 under trial |
| chain_to_mod_o | output | N | Daisy chain presented to each slot |
| chain_tail_o | output | 1 | Daisy chain after the last slot |
| side_sample_o | output | N | Sampled module-side sideband (isolated only) |
| side_drv_en_o | output | N | Sideband drive enable toward the module |
| side_drv_o | output | N | Sideband drive value toward the module |
| search_busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Sticky: search located a culprit |
| found_idx_o | output | $clog2(N) | Slot located by the last search |
| miss_o | output | 1 | Sticky: last search located nothing |

## Verification
The hardest state to reach is a search whose candidate list has holes, and a start request that arrives while a search is already running. The bench models a culprit slot by making the bus-healthy input a function of that slot's status. It first marks a lower slot faulty, then holds the start request high into the search, and measures the busy window in cycles to confirm that the faulty slot was skipped and the repeat request did nothing. A second search with no culprit runs through every slot and ends in a miss.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        SLOT_LINKED = 2'd0,
        SLOT_FAULTY = 2'd1,
        SLOT_PROBED = 2'd2
    } slot_state_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_PROBE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic found;
        logic miss;
    } search_flags_t;

    function automatic slot_state_e encode_slot(input logic faulty, input logic probed);
        if (faulty)      return SLOT_FAULTY;
        else if (probed) return SLOT_PROBED;
        else             return SLOT_LINKED;
    endfunction

endpackage

// File: rtl/sgc_slot_bank.sv
module sgc_slot_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fault_req_i,
    input  logic [N-1:0] hit_i,
    input  logic [N-1:0] rejoin_req_i,
    output logic [N-1:0] faulty_o
);
    logic [N-1:0] faulty_q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    assign set_v = fault_req_i | hit_i;
    assign clr_v = rejoin_req_i & ~set_v;

    always_ff @(posedge clk) begin
        if (rst) faulty_q <= '0;
        else     faulty_q <= (faulty_q | set_v) & ~clr_v;
    end

    assign faulty_o = faulty_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2
        a_r2_fault_latch: assert property (@(posedge clk) disable iff (rst)
            fault_req_i[i] |=> faulty_q[i]);
        // R9
        a_r9_rejoin_clears: assert property (@(posedge clk) disable iff (rst)
            (rejoin_req_i[i] && !fault_req_i[i] && !hit_i[i]) |=> !faulty_q[i]);
    end
endmodule

// File: rtl/sgc_search_seq.sv
module sgc_search_seq
    import sgc_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic [SW-1:0] settle_i,
    input  logic          bus_ok_i,
    input  logic [N-1:0]  faulty_i,
    input  logic [N-1:0]  rejoin_i,
    output logic [N-1:0]  trial_o,
    output logic [N-1:0]  hit_o,
    output search_flags_t flags_o,
    output logic [IW-1:0] found_idx_o
);
    seq_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic [SW-1:0] cnt_q;
    logic          found_q;
    logic          miss_q;
    logic [IW-1:0] fidx_q;

    // returns {valid, index} of the lowest non-faulty slot at or above 'from'
    function automatic logic [IW:0] pick_next(input logic [N-1:0] bad, input logic [IW:0] from);
        logic [IW:0] r;
        r = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (j >= int'(from) && !bad[j]) r = {1'b1, IW'(j)};
        end
        return r;
    endfunction

    logic [IW:0] first_c;
    logic [IW:0] next_c;
    logic        at_end;
    logic        hit;

    assign first_c = pick_next(faulty_i, '0);
    assign next_c  = pick_next(faulty_i, {1'b0, idx_q} + 1'b1);
    assign at_end  = (st_q == SEQ_PROBE) && (cnt_q == '0);
    assign hit     = at_end && bus_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            found_q <= 1'b0;
            miss_q  <= 1'b0;
            fidx_q  <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (found_q && rejoin_i[fidx_q]) found_q <= 1'b0;
                    if (go_i) begin
                        found_q <= 1'b0;
                        miss_q  <= 1'b0;
                        if (first_c[IW]) begin
                            st_q  <= SEQ_PROBE;
                            idx_q <= first_c[IW-1:0];
                            cnt_q <= settle_i;
                        end else begin
                            miss_q <= 1'b1;
                        end
                    end
                end
                SEQ_PROBE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (bus_ok_i) begin
                        found_q <= 1'b1;
                        fidx_q  <= idx_q;
                        st_q    <= SEQ_IDLE;
                    end else if (next_c[IW]) begin
                        idx_q <= next_c[IW-1:0];
                        cnt_q <= settle_i;
                    end else begin
                        miss_q <= 1'b1;
                        st_q   <= SEQ_IDLE;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    logic [N-1:0] sel_oh;
    assign sel_oh      = N'(1) << idx_q;
    assign trial_o     = (st_q == SEQ_PROBE) ? sel_oh : '0;
    assign hit_o       = hit ? sel_oh : '0;
    assign flags_o     = '{busy: (st_q == SEQ_PROBE), found: found_q, miss: miss_q};
    assign found_idx_o = fidx_q;

    // R6
    a_r6_trial_held: assert property (@(posedge clk) disable iff (rst)
        ((st_q == SEQ_PROBE) && cnt_q != '0) |=> $stable(trial_o));
    // R11
    a_r11_go_ignored: assert property (@(posedge clk) disable iff (rst)
        ((st_q == SEQ_PROBE) && go_i && cnt_q != '0) |=> ((st_q == SEQ_PROBE) && $stable(idx_q)));
    // R7
    a_r7_found_report: assert property (@(posedge clk) disable iff (rst)
        hit |=> (found_q && fidx_q == $past(idx_q) && st_q == SEQ_IDLE));
    // R8
    a_r8_miss_report: assert property (@(posedge clk) disable iff (rst)
        (at_end && !bus_ok_i && !next_c[IW]) |=> (miss_q && !found_q && st_q == SEQ_IDLE));
endmodule

// File: rtl/sgc_switch_map.sv
module sgc_switch_map
    import sgc_pkg::*;
#(
    parameter int N = 4,
    parameter int G = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   faulty_i,
    input  logic [N-1:0]   trial_i,
    input  logic [N*G-1:0] grp_cut_i,
    input  logic           chain_in_i,
    input  logic [N-1:0]   mod_chain_out_i,
    input  logic [N-1:0]   mod_side_in_i,
    input  logic [N-1:0]   side_drv_req_i,
    input  logic [N-1:0]   side_drv_val_i,
    output logic [N-1:0]   pwr_en_o,
    output logic [N*G-1:0] grp_en_o,
    output logic [2*N-1:0] status_o,
    output logic [N-1:0]   chain_to_mod_o,
    output logic           chain_tail_o,
    output logic [N-1:0]   side_sample_o,
    output logic [N-1:0]   side_drv_en_o,
    output logic [N-1:0]   side_drv_o
);
    logic [N-1:0] iso;
    logic [N:0]   link;

    for (genvar i = 0; i < N; i++) begin : g_slot
        slot_state_e st;
        assign st       = encode_slot(faulty_i[i], trial_i[i]);
        assign iso[i]   = (st != SLOT_LINKED);
        assign status_o[2*i +: 2] = st;
        assign pwr_en_o[i]        = !iso[i];
        assign side_sample_o[i]   = iso[i] & mod_side_in_i[i];
        assign side_drv_en_o[i]   = iso[i] & side_drv_req_i[i];
        assign side_drv_o[i]      = iso[i] & side_drv_req_i[i] & side_drv_val_i[i];

        for (genvar g = 0; g < G; g++) begin : g_grp
            assign grp_en_o[i*G+g] = !iso[i] && !grp_cut_i[i*G+g];
        end

        // R1, R2
        a_r2_all_cut: assert property (@(posedge clk) disable iff (rst)
            (status_o[2*i +: 2] != 2'd0) |-> (!pwr_en_o[i] && grp_en_o[i*G +: G] == '0));
        // R4
        a_r4_bridge: assert property (@(posedge clk) disable iff (rst)
            (status_o[2*i +: 2] != 2'd0) |-> (link[i+1] == chain_to_mod_o[i]));
        // R5
        a_r5_side_iso: assert property (@(posedge clk) disable iff (rst)
            (side_drv_en_o[i] || side_sample_o[i]) |-> (status_o[2*i +: 2] != 2'd0));
    end

    always_comb begin
        link[0] = chain_in_i;
        for (int i = 0; i < N; i++) begin
            link[i+1] = iso[i] ? link[i] : mod_chain_out_i[i];
        end
    end

    assign chain_to_mod_o = link[N-1:0];
    assign chain_tail_o   = link[N];
endmodule

// File: rtl/slot_guard_ctrl.sv
module slot_guard_ctrl
    import sgc_pkg::*;
#(
    parameter int N  = 4,
    parameter int G  = 3,
    parameter int SW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   fault_req_i,
    input  logic [N-1:0]   rejoin_req_i,
    input  logic [N*G-1:0] grp_cut_i,
    input  logic           search_go_i,
    input  logic [SW-1:0]  settle_cycles_i,
    input  logic           bus_ok_i,
    input  logic           chain_in_i,
    input  logic [N-1:0]   mod_chain_out_i,
    input  logic [N-1:0]   mod_side_in_i,
    input  logic [N-1:0]   side_drv_req_i,
    input  logic [N-1:0]   side_drv_val_i,
    output logic [N-1:0]   pwr_en_o,
    output logic [N*G-1:0] grp_en_o,
    output logic [2*N-1:0] slot_status_o,
    output logic [N-1:0]   chain_to_mod_o,
    output logic           chain_tail_o,
    output logic [N-1:0]   side_sample_o,
    output logic [N-1:0]   side_drv_en_o,
    output logic [N-1:0]   side_drv_o,
    output logic           search_busy_o,
    output logic           found_o,
    output logic [IW-1:0]  found_idx_o,
    output logic           miss_o
);
    logic [N-1:0]  faulty;
    logic [N-1:0]  trial;
    logic [N-1:0]  hit;
    search_flags_t flags;

    sgc_slot_bank #(.N(N)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .fault_req_i  (fault_req_i),
        .hit_i        (hit),
        .rejoin_req_i (rejoin_req_i),
        .faulty_o     (faulty)
    );

    sgc_search_seq #(.N(N), .SW(SW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .go_i        (search_go_i),
        .settle_i    (settle_cycles_i),
        .bus_ok_i    (bus_ok_i),
        .faulty_i    (faulty),
        .rejoin_i    (rejoin_req_i),
        .trial_o     (trial),
        .hit_o       (hit),
        .flags_o     (flags),
        .found_idx_o (found_idx_o)
    );

    sgc_switch_map #(.N(N), .G(G)) u_map (
        .clk             (clk),
        .rst             (rst),
        .faulty_i        (faulty),
        .trial_i         (trial),
        .grp_cut_i       (grp_cut_i),
        .chain_in_i      (chain_in_i),
        .mod_chain_out_i (mod_chain_out_i),
        .mod_side_in_i   (mod_side_in_i),
        .side_drv_req_i  (side_drv_req_i),
        .side_drv_val_i  (side_drv_val_i),
        .pwr_en_o        (pwr_en_o),
        .grp_en_o        (grp_en_o),
        .status_o        (slot_status_o),
        .chain_to_mod_o  (chain_to_mod_o),
        .chain_tail_o    (chain_tail_o),
        .side_sample_o   (side_sample_o),
        .side_drv_en_o   (side_drv_en_o),
        .side_drv_o      (side_drv_o)
    );

    assign search_busy_o = flags.busy;
    assign found_o       = flags.found;
    assign miss_o        = flags.miss;

    for (genvar i = 0; i < N; i++) begin : g_static
        // R10
        a_r10_static_switch: assert property (@(posedge clk) disable iff (rst)
            $rose(pwr_en_o[i]) |-> ($past(rejoin_req_i[i]) || $past(search_busy_o)));
    end
endmodule

// File: tb/sim_slot_guard_ctrl.sv
module sim_slot_guard_ctrl;
    localparam int N  = 4;
    localparam int G  = 3;
    localparam int SW = 8;
    localparam int IW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   fault_req = '0;
    logic [N-1:0]   rejoin_req = '0;
    logic [N*G-1:0] grp_cut = '0;
    logic           search_go = 1'b0;
    logic [SW-1:0]  settle = '0;
    logic           bus_ok;
    logic           chain_in = 1'b0;
    logic [N-1:0]   mod_chain_out = '0;
    logic [N-1:0]   mod_side_in = '0;
    logic [N-1:0]   side_drv_req = '0;
    logic [N-1:0]   side_drv_val = '0;
    logic [N-1:0]   pwr_en;
    logic [N*G-1:0] grp_en;
    logic [2*N-1:0] slot_status;
    logic [N-1:0]   chain_to_mod;
    logic           chain_tail;
    logic [N-1:0]   side_sample;
    logic [N-1:0]   side_drv_en;
    logic [N-1:0]   side_drv;
    logic           busy;
    logic           found;
    logic [IW-1:0]  found_idx;
    logic           miss;

    int n_checks = 0;
    int n_errors = 0;
    int culprit = -1;
    int exp_q[$];

    always #2 clk = ~clk;

    // bus model: healthy only while the culprit slot is off the bus
    always_comb begin
        bus_ok = 1'b0;
        for (int i = 0; i < N; i++)
            if (i == culprit && slot_status[2*i +: 2] != 2'd0) bus_ok = 1'b1;
    end

    slot_guard_ctrl #(.N(N), .G(G), .SW(SW)) u0 (
        .clk(clk), .rst(rst),
        .fault_req_i(fault_req), .rejoin_req_i(rejoin_req), .grp_cut_i(grp_cut),
        .search_go_i(search_go), .settle_cycles_i(settle), .bus_ok_i(bus_ok),
        .chain_in_i(chain_in), .mod_chain_out_i(mod_chain_out),
        .mod_side_in_i(mod_side_in), .side_drv_req_i(side_drv_req), .side_drv_val_i(side_drv_val),
        .pwr_en_o(pwr_en), .grp_en_o(grp_en), .slot_status_o(slot_status),
        .chain_to_mod_o(chain_to_mod), .chain_tail_o(chain_tail),
        .side_sample_o(side_sample), .side_drv_en_o(side_drv_en), .side_drv_o(side_drv),
        .search_busy_o(busy), .found_o(found), .found_idx_o(found_idx), .miss_o(miss)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: when a search ends, pop the expected verdict and compare
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected search end", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e < 0) begin
                    check("R8 miss flag", {31'b0, miss}, 1);
                    check("R8 found low", {31'b0, found}, 0);
                end else begin
                    check("R7 found flag", {31'b0, found}, 1);
                    check("R7 found index", {30'b0, found_idx}, e);
                end
            end
        end
        prev_busy = busy;
    end

    task automatic pulse_fault(input logic [N-1:0] v);
        fault_req = v; @(negedge clk); fault_req = '0;
    endtask

    task automatic pulse_rejoin(input logic [N-1:0] v);
        rejoin_req = v; @(negedge clk); rejoin_req = '0;
    endtask

    // driver: launches a search and pushes the expected verdict
    task automatic run_search(input int s, input int cul, input int first,
                              input int exp_cycles, input int exp_idx, input int hold);
        int n;
        settle = SW'(s);
        culprit = cul;
        exp_q.push_back(exp_idx);
        search_go = 1'b1;
        @(negedge clk);
        check("R6 first trial status", {30'b0, slot_status[2*first +: 2]}, 2);
        check("R6 first trial power off", {31'b0, pwr_en[first]}, 0);
        n = 0;
        while (busy) begin
            n++;
            if (n >= hold) search_go = 1'b0;
            @(negedge clk);
        end
        search_go = 1'b0;
        check("R6 R11 search duration", n, exp_cycles);
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 power", {28'b0, pwr_en}, 32'hF);
        check("R1 groups", {20'b0, grp_en}, 32'hFFF);
        check("R1 status", {24'b0, slot_status}, 0);
        check("R1 flags", {29'b0, busy, found, miss}, 0);

        // R2, R4, R5
        chain_in = 1'b1; mod_chain_out = 4'b0001;
        mod_side_in = 4'b1010; side_drv_req = 4'hF; side_drv_val = 4'hF;
        pulse_fault(4'b0010);
        check("R2 status", {24'b0, slot_status}, 32'h04);
        check("R2 power", {28'b0, pwr_en}, 32'hD);
        check("R2 groups", {20'b0, grp_en}, 32'hFC7);
        check("R4 chain bypass", {28'b0, chain_to_mod}, 32'h7);
        check("R4 chain tail", {31'b0, chain_tail}, 0);
        check("R5 sample", {28'b0, side_sample}, 32'h2);
        check("R5 drive enable", {28'b0, side_drv_en}, 32'h2);
        check("R5 drive value", {28'b0, side_drv}, 32'h2);

        // R9: rejoin on a connected slot has no effect, then on the faulty one
        pulse_rejoin(4'b0001);
        check("R9 no effect status", {24'b0, slot_status}, 32'h04);
        check("R9 no effect power", {28'b0, pwr_en}, 32'hD);
        pulse_rejoin(4'b0010);
        check("R9 rejoin power", {28'b0, pwr_en}, 32'hF);
        check("R9 rejoin status", {24'b0, slot_status}, 0);
        check("R4 chain restored", {28'b0, chain_to_mod}, 32'h3);
        check("R5 connected sample", {28'b0, side_sample}, 0);

        // R3
        grp_cut = 12'h080;
        @(negedge clk);
        check("R3 single group", {20'b0, grp_en}, 32'hF7F);
        check("R3 power kept", {28'b0, pwr_en}, 32'hF);
        grp_cut = '0;
        @(negedge clk);

        // R6, R7: culprit slot 2, settle 3 -> 3 trials of 4 cycles
        run_search(3, 2, 0, 12, 2, 1);
        check("R7 status after", {24'b0, slot_status}, 32'h10);
        check("R7 power after", {28'b0, pwr_en}, 32'hB);
        pulse_rejoin(4'b0100);
        check("R9 found cleared", {31'b0, found}, 0);
        check("R9 power back", {28'b0, pwr_en}, 32'hF);

        // R6, R11: slot 0 faulty is skipped, go held into the search
        pulse_fault(4'b0001);
        run_search(0, 3, 1, 3, 3, 2);
        check("R7 status skip", {24'b0, slot_status}, 32'h41);
        pulse_rejoin(4'b1001);
        check("R9 both back", {24'b0, slot_status}, 0);

        // R8: no culprit, settle 1 -> 4 trials of 2 cycles
        run_search(1, -1, 0, 8, -1, 1);
        check("R8 all connected", {24'b0, slot_status}, 0);
        check("R8 power", {28'b0, pwr_en}, 32'hF);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("R7 pending verdicts", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule